// File: doc/BRIEF.md
# NAND Hamming ECC Accumulator

This block computes a single-error-correcting parity code over the data that flows to or from a NAND device. The code is two-dimensional. The column half is a set of parity pairs taken across the bit positions of every beat. The row half is a set of parity pairs taken across the index of each beat inside the block. Only beats tagged with one configured chip select take part. Reads, writes, commands and status beats are all treated alike, and they are folded in strictly in the order they arrive.

Software first clears the context and arms the block, normally both in the same cycle. It then moves the data. Each time a programmed number of beats has been folded in, the finished code word is written into the next free slot of a bank of up to nine result registers, and that slot's valid flag goes high. Once the programmed number of results has been stored, the block disarms itself and raises `done`. Beats that arrive after that are ignored until the next clear.

Top module: `nand_parity_acc`

## Requirements
- R1: Result bits [7:0] hold the column code of the block. Bit 2m is the XOR, over every beat, of the data bits whose bit index has bit m set. Bit 2m+1 is the XOR of the data bits whose index has bit m clear.
- R2: Result bits [25:8] hold the row code. Bit 8+2j is the XOR of the parities of the beats whose in-block index has bit j set. Bit 9+2j is the XOR of the parities of the beats whose index has bit j clear, for j = 0..8. Bits [31:26] read 0.
- R3: With `cfg_wide`=0, a beat is the low byte of `beat_data`, and bits [15:8] have no effect on the result. Result bits [7:6] are 0 in this mode.
- R4: With `cfg_wide`=1, a beat is all 16 bits of `beat_data`, and four column pairs (m = 0..3) are formed.
- R5: A beat whose `beat_cs` differs from `cfg_cs` leaves the result unchanged.
- R6: Beats that arrive while `busy` is low are ignored.
- R7: Slots are filled in order starting at slot 0. A slot's valid flag rises on the clock edge that accepts the last beat of its block, never earlier, and it stays high until a clear.
- R8: A block is `cfg_blk_m1`+1 beats long, from 1 to 512 beats.
- R9: The block stores `cfg_res_m1`+1 results, with the count capped at nine. On the edge that stores the last result, `busy` falls and `done` rises. Later beats change no slot.
- R10: A `ctx_clr` pulse clears the accumulators, the slot pointer, every slot, every valid flag and `done`, and it takes priority over a beat in the same cycle. If `arm` is high in the same cycle, `busy` is high afterwards.
- R11: After reset, `busy`, `done`, every valid flag and every slot are 0.
- R12: `arm` has no effect while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cs | input | 3 | Chip select bound to the context |
| cfg_wide | input | 1 | 1: 16-bit beats, 0: 8-bit beats |
| cfg_blk_m1 | input | 9 | Beats per block minus one |
| cfg_res_m1 | input | 4 | Number of results minus one (capped at 8) |
| ctx_clr | input | 1 | Context clear pulse |
| arm | input | 1 | Start accumulation |
| beat_vld | input | 1 | Data beat strobe |
| beat_cs | input | 3 | Chip select tag of the beat |
| beat_data | input | 16 | Beat data |
| busy | output | 1 | Context is armed and accumulating |
| done | output | 1 | All programmed results are stored |
| res_valid | output | 9 | Per-slot valid flags |
| res_flat | output | 288 | Slot k occupies bits [32k+31:32k] |

## Verification
The bench uses the default parameters: eight chip selects, nine slots and 512-beat blocks. With these values, a full-length 16-bit block exercises all nine row pairs, and a run that fills every slot reaches the point where the result count is capped. Single-beat blocks taken from a vector table pin down the column layout bit by bit. Multi-block runs with interleaved beats for other chip selects are compared against a bit-level model of the code that lives in the bench.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
    localparam int unsigned ECC_RES_W    = 32;
    localparam int unsigned ECC_SLOT_MAX = 9;
    localparam int unsigned ECC_BLK_MAX  = 512;
    localparam int unsigned ECC_CS_NUM   = 8;
    localparam int unsigned ECC_DATA_W   = 16;
endpackage

// File: rtl/nand_col_parity.sv
module nand_col_parity #(
    parameter int unsigned DATA_W = 16,
    localparam int unsigned LOG_W = $clog2(DATA_W),
    localparam int unsigned LOG_N = LOG_W - 1,
    localparam int unsigned COL_W = 2 * LOG_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic              wide,
    output logic [COL_W-1:0]  col
);
    for (genvar m = 0; m < LOG_W; m++) begin : g_pair
        logic hi, lo;
        always_comb begin
            hi = 1'b0;
            lo = 1'b0;
            for (int i = 0; i < DATA_W; i++) begin
                if (((i >> m) & 1) == 1) hi = hi ^ data[i];
                else                     lo = lo ^ data[i];
            end
        end
        if (m >= LOG_N) begin : g_wide_only
            assign col[2*m]   = wide & hi;
            assign col[2*m+1] = wide & lo;
        end else begin : g_both
            assign col[2*m]   = hi;
            assign col[2*m+1] = lo;
        end
    end
endmodule

// File: rtl/nand_row_parity.sv
module nand_row_parity #(
    parameter int unsigned IDX_W = 9,
    localparam int unsigned ROW_W = 2 * IDX_W
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             par,
    output logic [ROW_W-1:0] row
);
    for (genvar j = 0; j < IDX_W; j++) begin : g_bit
        assign row[2*j]   = par & idx[j];
        assign row[2*j+1] = par & ~idx[j];
    end
endmodule

// File: rtl/nand_result_bank.sv
module nand_result_bank #(
    parameter int unsigned SLOTS = 9,
    parameter int unsigned RES_W = 32,
    localparam int unsigned PTR_W = $clog2(SLOTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   wr_en,
    input  logic [PTR_W-1:0]       wr_ptr,
    input  logic [RES_W-1:0]       wr_data,
    output logic [SLOTS-1:0]       vld,
    output logic [SLOTS*RES_W-1:0] res_flat
);
    typedef struct packed {
        logic [SLOTS-1:0][RES_W-1:0] res;
        logic [SLOTS-1:0]            vld;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else if (wr_en && (wr_ptr < PTR_W'(SLOTS))) begin
            s_d.res[wr_ptr] = wr_data;
            s_d.vld[wr_ptr] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign vld      = s_q.vld;
    assign res_flat = s_q.res;

    for (genvar k = 0; k < SLOTS; k++) begin : g_chk
        p_valid_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.vld[k] && !clr |=> s_q.vld[k]);
    end

    p_write_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_ptr < PTR_W'(SLOTS)));
endmodule

// File: rtl/nand_parity_acc.sv
module nand_parity_acc
    import nand_ecc_pkg::*;
#(
    parameter int unsigned NUM_CS  = ECC_CS_NUM,
    parameter int unsigned DATA_W  = ECC_DATA_W,
    parameter int unsigned BLK_MAX = ECC_BLK_MAX,
    parameter int unsigned SLOTS   = ECC_SLOT_MAX,
    parameter int unsigned RES_W   = ECC_RES_W,
    localparam int unsigned CS_W   = $clog2(NUM_CS),
    localparam int unsigned IDX_W  = $clog2(BLK_MAX),
    localparam int unsigned PTR_W  = $clog2(SLOTS + 1),
    localparam int unsigned COL_W  = 2 * $clog2(DATA_W),
    localparam int unsigned ROW_W  = 2 * IDX_W,
    localparam int unsigned PAD_W  = RES_W - ROW_W - COL_W,
    localparam int unsigned HALF_W = DATA_W / 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CS_W-1:0]        cfg_cs,
    input  logic                   cfg_wide,
    input  logic [IDX_W-1:0]       cfg_blk_m1,
    input  logic [PTR_W-1:0]       cfg_res_m1,
    input  logic                   ctx_clr,
    input  logic                   arm,
    input  logic                   beat_vld,
    input  logic [CS_W-1:0]        beat_cs,
    input  logic [DATA_W-1:0]      beat_data,
    output logic                   busy,
    output logic                   done,
    output logic [SLOTS-1:0]       res_valid,
    output logic [SLOTS*RES_W-1:0] res_flat
);
    typedef struct packed {
        logic             run;
        logic             done;
        logic [IDX_W-1:0] cnt;
        logic [PTR_W-1:0] ptr;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } ctx_t;

    ctx_t c_d, c_q;

    logic [DATA_W-1:0] beat_m;
    logic [COL_W-1:0]  beat_col;
    logic [ROW_W-1:0]  beat_row;
    logic              beat_par;
    logic              take;
    logic              last_beat;
    logic [PTR_W-1:0]  res_last;
    logic              wr_en;
    logic [RES_W-1:0]  wr_data;
    logic [COL_W-1:0]  col_new;
    logic [ROW_W-1:0]  row_new;

    assign beat_m   = cfg_wide ? beat_data : {{HALF_W{1'b0}}, beat_data[HALF_W-1:0]};
    assign beat_par = ^beat_m;

    nand_col_parity #(.DATA_W(DATA_W)) u_col (
        .data (beat_m),
        .wide (cfg_wide),
        .col  (beat_col)
    );

    nand_row_parity #(.IDX_W(IDX_W)) u_row (
        .idx (c_q.cnt),
        .par (beat_par),
        .row (beat_row)
    );

    assign res_last  = (cfg_res_m1 > PTR_W'(SLOTS - 1)) ? PTR_W'(SLOTS - 1) : cfg_res_m1;
    assign take      = c_q.run && beat_vld && (beat_cs == cfg_cs) && !ctx_clr;
    assign last_beat = (c_q.cnt == cfg_blk_m1);
    assign col_new   = c_q.col ^ beat_col;
    assign row_new   = c_q.row ^ beat_row;

    always_comb begin
        c_d     = c_q;
        wr_en   = 1'b0;
        wr_data = {{PAD_W{1'b0}}, row_new, col_new};
        if (ctx_clr) begin
            c_d     = '0;
            c_d.run = arm;
        end else begin
            if (arm && !c_q.run && !c_q.done) c_d.run = 1'b1;
            if (take) begin
                if (last_beat) begin
                    wr_en   = 1'b1;
                    c_d.col = '0;
                    c_d.row = '0;
                    c_d.cnt = '0;
                    c_d.ptr = c_q.ptr + PTR_W'(1);
                    if (c_q.ptr == res_last) begin
                        c_d.run  = 1'b0;
                        c_d.done = 1'b1;
                    end
                end else begin
                    c_d.col = col_new;
                    c_d.row = row_new;
                    c_d.cnt = c_q.cnt + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    nand_result_bank #(.SLOTS(SLOTS), .RES_W(RES_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctx_clr),
        .wr_en    (wr_en),
        .wr_ptr   (c_q.ptr),
        .wr_data  (wr_data),
        .vld      (res_valid),
        .res_flat (res_flat)
    );

    assign busy = c_q.run;
    assign done = c_q.done;

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.done |-> !c_q.run);

    p_fill_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid & (res_valid + SLOTS'(1))) == '0);

    p_valid_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(res_valid) == int'(c_q.ptr));

    p_foreign_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld && (beat_cs != cfg_cs) && !ctx_clr |=> $stable(c_q.cnt) && $stable(res_valid));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_clr |=> (res_valid == '0) && !c_q.done);

    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.run && !ctx_clr |=> $stable(c_q.cnt) && $stable(res_valid));
endmodule

// File: tb/nand_parity_acc_tb.sv
module nand_parity_acc_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    localparam logic [48:0] VEC [NVEC] = '{
        {1'b0, 16'h0001, 32'h02AAAA2A},
        {1'b0, 16'h0080, 32'h02AAAA15},
        {1'b0, 16'h0003, 32'h00000003},
        {1'b0, 16'hAB00, 32'h00000000},
        {1'b1, 16'h8000, 32'h02AAAA55},
        {1'b1, 16'h0100, 32'h02AAAA6A},
        {1'b0, 16'h0000, 32'h00000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_cs = 3'd2;
    logic        cfg_wide = 1'b0;
    logic [8:0]  cfg_blk_m1 = '0;
    logic [3:0]  cfg_res_m1 = '0;
    logic        ctx_clr = 1'b0;
    logic        arm = 1'b0;
    logic        beat_vld = 1'b0;
    logic [2:0]  beat_cs = '0;
    logic [15:0] beat_data = '0;
    logic        busy, done;
    logic [8:0]  res_valid;
    logic [287:0] res_flat;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] blk [1024];

    nand_parity_acc dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_cs(cfg_cs), .cfg_wide(cfg_wide),
        .cfg_blk_m1(cfg_blk_m1), .cfg_res_m1(cfg_res_m1), .ctx_clr(ctx_clr),
        .arm(arm), .beat_vld(beat_vld), .beat_cs(beat_cs), .beat_data(beat_data),
        .busy(busy), .done(done), .res_valid(res_valid), .res_flat(res_flat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] slot(int k);
        return res_flat[k*32 +: 32];
    endfunction

    function automatic logic [31:0] model(int base, int n, bit wide);
        logic [15:0] cx = '0;
        logic [8:0]  hi = '0;
        logic [8:0]  lo = '0;
        logic [31:0] r  = '0;
        logic [15:0] d;
        logic        p, a, b;
        for (int k = 0; k < n; k++) begin
            d  = wide ? blk[base+k] : {8'h00, blk[base+k][7:0]};
            cx = cx ^ d;
            p  = ^d;
            for (int j = 0; j < 9; j++) begin
                if (((k >> j) & 1) == 1) hi[j] = hi[j] ^ p;
                else                     lo[j] = lo[j] ^ p;
            end
        end
        for (int m = 0; m < (wide ? 4 : 3); m++) begin
            a = 1'b0;
            b = 1'b0;
            for (int i = 0; i < (wide ? 16 : 8); i++) begin
                if (((i >> m) & 1) == 1) a = a ^ cx[i];
                else                     b = b ^ cx[i];
            end
            r[2*m]   = a;
            r[2*m+1] = b;
        end
        for (int j = 0; j < 9; j++) begin
            r[8+2*j] = hi[j];
            r[9+2*j] = lo[j];
        end
        return r;
    endfunction

    task automatic start(logic [8:0] bm1, logic [3:0] rm1, logic w, logic do_arm);
        cfg_blk_m1 = bm1;
        cfg_res_m1 = rm1;
        cfg_wide   = w;
        ctx_clr    = 1'b1;
        arm        = do_arm;
        @(negedge clk);
        ctx_clr    = 1'b0;
        arm        = 1'b0;
    endtask

    task automatic send(logic [2:0] cs, logic [15:0] d);
        beat_cs   = cs;
        beat_data = d;
        beat_vld  = 1'b1;
        @(negedge clk);
        beat_vld  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 busy", 32'(busy), 0);
        check("R11 done", 32'(done), 0);
        check("R11 valid", 32'(res_valid), 0);
        check("R11 slot0", slot(0), 0);

        // Vector table: single-beat blocks, R1 R3 R4 R8
        for (int v = 0; v < NVEC; v++) begin
            start(9'd0, 4'd0, VEC[v][48], 1'b1);
            send(3'd2, VEC[v][47:32]);
            check("R1 R3 R4 table result", slot(0), VEC[v][31:0]);
            check("R8 single beat valid", 32'(res_valid), 32'h1);
        end

        // R6 beats while idle are ignored
        start(9'd3, 4'd2, 1'b0, 1'b0);
        send(3'd2, 16'h00FF);
        send(3'd2, 16'h0012);
        check("R6 idle busy", 32'(busy), 0);
        check("R6 idle valid", 32'(res_valid), 0);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        check("R6 armed busy", 32'(busy), 1);

        // Three blocks of four 8-bit beats, foreign beats interleaved (R5 R7 R2)
        for (int k = 0; k < 12; k++) blk[k] = 16'((k * 37 + 5) ^ (k << 9));
        for (int b = 0; b < 3; b++) begin
            for (int k = 0; k < 4; k++) begin
                send(3'd5, 16'hFFFF);
                send(3'd2, blk[b*4+k]);
                if (b == 0 && k == 2) check("R7 partial block not valid", 32'(res_valid), 0);
            end
            check("R7 fill order", 32'(res_valid), (32'h1 << (b + 1)) - 1);
            check("R5 R2 block result", slot(b), model(b*4, 4, 1'b0));
        end
        check("R9 done after last", 32'(done), 1);
        check("R9 busy after last", 32'(busy), 0);
        send(3'd2, 16'h5A5A);
        send(3'd2, 16'h0F0F);
        check("R9 late beats valid", 32'(res_valid), 32'h7);
        check("R9 late beats slot2", slot(2), model(8, 4, 1'b0));
        check("R9 late beats slot3", slot(3), 0);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        check("R12 arm while done", 32'(busy), 0);

        // R10 clear without arm
        start(9'd3, 4'd2, 1'b0, 1'b0);
        check("R10 clear valid", 32'(res_valid), 0);
        check("R10 clear done", 32'(done), 0);
        check("R10 clear slot0", slot(0), 0);
        check("R10 clear busy", 32'(busy), 0);

        // R8 R2 R4 maximum block, 16-bit
        for (int k = 0; k < 512; k++) blk[k] = 16'((k * 16'h9E37) ^ (k << 3) ^ (k >> 2));
        start(9'd511, 4'd0, 1'b1, 1'b1);
        for (int k = 0; k < 512; k++) begin
            if (k == 511) check("R8 not valid before last", 32'(res_valid), 0);
            send(3'd2, blk[k]);
        end
        check("R8 R2 max block result", slot(0), model(0, 512, 1'b1));
        check("R8 max block valid", 32'(res_valid), 1);

        // R9 result count capped at nine
        for (int k = 0; k < 18; k++) blk[k] = 16'(k * 16'h1357 + 16'h2468);
        start(9'd1, 4'd15, 1'b1, 1'b1);
        for (int k = 0; k < 18; k++) send(3'd2, blk[k]);
        check("R9 cap valid", 32'(res_valid), 32'h1FF);
        check("R9 cap done", 32'(done), 1);
        check("R9 cap slot8", slot(8), model(16, 2, 1'b1));
        send(3'd2, 16'hFFFF);
        check("R9 cap slot8 stable", slot(8), model(16, 2, 1'b1));

        // R10 clear with arm beats a simultaneous beat
        start(9'd1, 4'd0, 1'b0, 1'b1);
        send(3'd2, 16'h0077);
        ctx_clr   = 1'b1;
        arm       = 1'b1;
        beat_cs   = 3'd2;
        beat_data = 16'h00C3;
        beat_vld  = 1'b1;
        @(negedge clk);
        ctx_clr  = 1'b0;
        arm      = 1'b0;
        beat_vld = 1'b0;
        check("R10 clr plus arm busy", 32'(busy), 1);
        blk[0] = 16'h0011;
        blk[1] = 16'h0090;
        send(3'd2, blk[0]);
        check("R10 no early valid", 32'(res_valid), 0);
        send(3'd2, blk[1]);
        check("R10 fresh block result", slot(0), model(0, 2, 1'b0));
        check("R3 narrow top pair zero", 32'(slot(0)[7:6]), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule